// File: doc/BRIEF.md
# Asynchronous Byte-Bus Register Slave

This block is a small byte-wide register file that answers a host on an asynchronous 8-bit parallel bus. The host presents a 6-bit address, a read/write select and, for writes, a data byte. It then pulls an active-low select strobe low for a few core clocks. The block runs on its own faster core clock. It brings the select strobe into that domain through a synchronizer and acts once on each detected falling edge. At that edge it samples the address, the direction and the write byte as they stand.

Writes land in one of 48 byte locations. Reads return the stored byte, or zero for the 16 addresses above the last location. The returned byte is driven onto the shared data pins only while the strobe is low and the direction line says read. The pins float at every other time, so the host can turn the bus around between accesses. Storage has no reset and is laid out for block RAM. The synchronous active-high reset clears only the strobe and access control logic.

Top module: `mpi_bus_slave`

## Requirements
- R1: While `rst` is high, bus accesses have no effect. Bytes stored before reset are kept, because reset does not clear storage.
- R2: A write (select low, `bus_rw` = 0) to address 0..47 stores the data byte. A later read (`bus_rw` = 1) of that address returns it, and every location holds its own byte.
- R3: The block drives `bus_data` only while `bus_cs_n` is 0 and `bus_rw` is 1. Otherwise the pins are high impedance.
- R4: The read byte is valid on `bus_data` no later than six core clock periods after `bus_cs_n` falls.
- R5: Writes to addresses 48..63 change no stored byte.
- R6: Reads from addresses 48..63 return 8'h00.
- R7: Each low period of the select strobe performs exactly one access. It uses the address, direction and data sampled shortly after the strobe falls, and later changes on those lines during the same low period are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset of the control logic |
| bus_cs_n | input | 1 | Asynchronous active-low select strobe from the host |
| bus_rw | input | 1 | Direction: 1 read, 0 write |
| bus_addr | input | 6 | Location address |
| bus_data | inout | 8 | Shared tri-state data bus |

## Verification
The two functions that can fall in neighbouring cycles on the same location are the commit of a write and the read capture of the access that follows it. A write is committed one cycle after its edge is seen. A read that follows at the shortest legal gap, with the direction line flipped in that gap, fetches the same location only a few cycles later. This case is provoked by writing a location and reading it straight back, and it is judged by requiring the fresh byte rather than the old one. A second case changes the host data in the middle of a strobe. It checks that only the byte sampled at the edge is stored.

// File: rtl/mpi_pkg.sv
package mpi_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/mpi_strobe_sync.sv
module mpi_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n_async,
  output logic strobe_fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chain_q;
  logic         last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q     <= '1;
      last_q      <= 1'b1;
      strobe_fall <= 1'b0;
    end else begin
      chain_q     <= {chain_q[TOP-1:0], strobe_n_async};
      last_q      <= chain_q[TOP];
      strobe_fall <= last_q & ~chain_q[TOP];
    end
  end

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe_fall |=> !strobe_fall); // R7
endmodule

// File: rtl/mpi_access_ctl.sv
module mpi_access_ctl
  import mpi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_fall,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              rd_zero
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(DEPTH - 1);

  acc_kind_t         kind_q;
  logic              inr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= ACC_NONE;
      inr_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      kind_q <= strobe_fall ? (rw ? ACC_READ : ACC_WRITE) : ACC_NONE;
      if (strobe_fall) begin
        addr_q <= addr;
        data_q <= din;
        inr_q  <= (addr <= LAST_ADDR);
      end
    end
  end

  assign wr_en   = (kind_q == ACC_WRITE) && inr_q;
  assign rd_en   = (kind_q == ACC_READ) && inr_q;
  assign rd_zero = (kind_q == ACC_READ) && !inr_q;
  assign wr_addr = addr_q[IDX_W-1:0];
  assign rd_addr = addr_q[IDX_W-1:0];
  assign wr_data = data_q;

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= LAST_IDX)); // R5
  AST_ACT_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en || rd_zero) |-> $past(strobe_fall)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en || rd_zero) |=> !(wr_en || rd_en || rd_zero)); // R7
endmodule

// File: rtl/mpi_reg_array.sv
module mpi_reg_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/mpi_bus_slave.sv
module mpi_bus_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              strobe_fall;
  logic              wr_en, rd_en, rd_zero;
  logic [IDX_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              zero_q;
  logic [DATA_W-1:0] out_byte;
  logic              drive_en;

  mpi_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .strobe_n_async(bus_cs_n), .strobe_fall(strobe_fall)
  );

  mpi_access_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rst(rst), .strobe_fall(strobe_fall), .rw(bus_rw),
    .addr(bus_addr), .din(bus_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_zero(rd_zero)
  );

  mpi_reg_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) zero_q <= 1'b0;
    else if (rd_en || rd_zero) zero_q <= rd_zero;
  end

  assign out_byte = zero_q ? '0 : rd_data;
  assign drive_en = !bus_cs_n && bus_rw;
  assign bus_data = drive_en ? out_byte : {DATA_W{1'bz}};

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_zero) |-> (out_byte == '0)); // R6
  AST_NO_WR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !wr_en); // R7
endmodule

// File: tb/mpi_bus_slave_tb_top.sv
module mpi_bus_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] host_d = '0;
  logic host_oe = 1'b0;
  wire  [7:0] bus_data;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign bus_data = host_oe ? host_d : 8'bz;
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (bus_data[g]);
  end

  mpi_bus_slave dut_i (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rw(rw),
    .bus_addr(addr), .bus_data(bus_data)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk); addr = a; rw = 1'b0; host_d = d; host_oe = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (10) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk); host_oe = 1'b0; rw = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(logic [5:0] a, int wait_n, output logic [7:0] v);
    @(negedge clk); addr = a; rw = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (wait_n) @(negedge clk);
    v = bus_data;
    repeat (10 - wait_n) @(negedge clk);
    cs_n = 1'b1;
    #1 chk("R3 release after read", bus_data, 8'hFF);
    @(negedge clk); rw = 1'b0;
    repeat (2) @(negedge clk);
    rw = 1'b1;
  endtask

  task automatic t_fill;
    logic [7:0] v;
    for (int i = 0; i < 48; i++) bus_write(6'(i), pat(i));
    for (int i = 47; i >= 0; i--) begin
      bus_read(6'(i), 9, v);
      chk("R2 readback", v, pat(i));
    end
  endtask

  task automatic t_out_of_range;
    logic [7:0] v;
    for (int i = 48; i < 64; i++) bus_write(6'(i), 8'hEE);
    for (int i = 0; i < 48; i++) begin
      bus_read(6'(i), 9, v);
      chk("R5 untouched", v, pat(i));
    end
    for (int i = 48; i < 64; i++) begin
      bus_read(6'(i), 9, v);
      chk("R6 zero read", v, 8'h00);
    end
  endtask

  task automatic t_drive;
    logic [7:0] v;
    bus_read(6'd3, 9, v);
    @(negedge clk); addr = 6'd3; rw = 1'b1;
    #1 chk("R3 idle cs high rw high", bus_data, 8'hFF);
    @(negedge clk); rw = 1'b0; cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 no drive while writing-select", bus_data, 8'hFF);
    cs_n = 1'b1;
    @(negedge clk); rw = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_early;
    logic [7:0] v;
    bus_read(6'd20, 6, v);
    chk("R4 valid six cycles after fall", v, pat(20));
    bus_read(6'd50, 6, v);
    chk("R4 zero valid six cycles after fall", v, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    @(negedge clk); addr = 6'd7; rw = 1'b0; host_d = 8'h5A; host_oe = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (7) @(negedge clk);
    host_d = 8'hC3; addr = 6'd8;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk); host_oe = 1'b0; rw = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(6'd7, 9, v);
    chk("R7 data sampled at edge", v, 8'h5A);
    bus_read(6'd8, 9, v);
    chk("R7 late address ignored", v, pat(8));
    bus_write(6'd9, 8'h81);
    bus_read(6'd9, 9, v);
    chk("R2 write then immediate read", v, 8'h81);
  endtask

  task automatic t_reset_hold;
    logic [7:0] v;
    @(negedge clk); rst = 1'b1;
    bus_write(6'd5, 8'h3C);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk("R1 bus idle after reset", bus_data, 8'hFF);
    bus_read(6'd5, 9, v);
    chk("R1 access ignored in reset, storage kept", v, pat(5));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 chk("R1 idle after reset", bus_data, 8'hFF);
    t_fill();
    t_out_of_range();
    t_drive();
    t_early();
    t_reset_hold();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule